// File: doc/BRIEF.md
# Two-Cycle Wide Search Command Capture

This block sits behind a narrow host command bus. It turns a 144-bit search command, which the host spreads over two back-to-back cycles, into a single internal search request. Each cycle carries a 2-bit command code, a strobe that marks the command as valid, some parameter bits and 72 bits of key data. The parameter bits mean something different in each cycle.

- **First cycle:** the parameter bits give the global-mask pair index and the upper result-address bits. The data bus carries key bits [143:72].
- **Second cycle:** the parameter bits give the comparand pair and the result register. The data bus carries key bits [71:0].

The block joins the two halves into one key. It writes the key into the selected comparand register pair. One cycle after the second command cycle it raises a single-cycle request strobe, with the key and all indices held beside it. If the second cycle does not continue the search, the stored half is dropped and a one-cycle protocol-error pulse is raised.

The request leaves as a plain strobe, so there is no back-pressure. A consumer must take the request in the cycle the strobe is high, and the held fields stay valid until the next accepted search. Any comparand pair can be read back combinationally through a select input.

Top module: `srch_cmd_capture`

## Requirements
- R1: After reset, search_start and proto_err are low, every comparand pair reads back as zero and no first half is pending.
- R2: A search is accepted when cmd_valid is high and cmd_code equals 2'b10 in two consecutive cycles. search_start is high for exactly one cycle, in the cycle after the second one.
- R3: search_key[143:72] is the cmd_data sampled in the first cycle, and search_key[71:0] is the cmd_data sampled in the second cycle.
- R4: search_mask_sel is {cmd_ext, cmd_arg[5:3]}, sampled in the first cycle.
- R5: search_addr_hi is cmd_arg[8:6] sampled in the first cycle. It is destined for result-address bits [23:21].
- R6: search_res_sel is cmd_arg[8:6] sampled in the second cycle. It picks one of eight result registers.
- R7: search_cmp_sel is cmd_arg[5:2] sampled in the second cycle. The full key is written into that comparand pair, which cmp_rd_key shows from the cycle after the second one. All other pairs keep their contents.
- R8: A cycle cannot open a search, and has no effect on any output, if cmd_valid is low, cmd_code is not 2'b10, or cmd_arg[2] is 1.
- R9: If a first half is pending and the next cycle lacks cmd_valid high with cmd_code 2'b10, the half is discarded. proto_err then pulses for one cycle in the following cycle, with no search_start and no comparand write.
- R10: A new first cycle may directly follow a second cycle, so searches run at one every two cycles without a gap.
- R11: The search_key, search_mask_sel, search_cmp_sel, search_res_sel and search_addr_hi outputs hold their values until the next accepted search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command cycle valid |
| cmd_code | input | 2 | Command code; 2'b10 is search |
| cmd_arg | input | 7 | Parameter bits [8:2], meaning depends on the cycle |
| cmd_ext | input | 1 | Parameter bit 10, mask index MSB in the first cycle |
| cmd_data | input | 72 | Key half |
| cmp_rd_sel | input | 4 | Comparand pair readback select |
| cmp_rd_key | output | 144 | Selected comparand pair contents |
| search_start | output | 1 | One-cycle search request strobe |
| search_key | output | 144 | Assembled search key |
| search_mask_sel | output | 4 | Global-mask pair index |
| search_cmp_sel | output | 4 | Comparand pair index |
| search_res_sel | output | 3 | Result register index |
| search_addr_hi | output | 3 | Upper result-address bits |
| proto_err | output | 1 | One-cycle pulse on an aborted second cycle |

## Verification
Every result sits one register behind the second command cycle. search_start, the held fields and proto_err are due in the cycle right after the second cycle is sampled, and the new comparand contents are readable from that same cycle. The driver applies each command cycle at a falling edge and pushes the expected request when it drives the second cycle. The monitor samples at every falling edge, so it sees a strobe one edge after the second cycle's rising edge and compares it against the head of the queue. Error pulses are counted against the number of aborted commands, and a final sweep of all comparand pairs checks the stored keys against a bench model.

// File: rtl/srch_cap_pkg.sv
package srch_cap_pkg;
  localparam logic [1:0] CODE_SEARCH = 2'b10;
  localparam int MASK_IDX_W = 4;
  localparam int CMP_IDX_W  = 4;
  localparam int RES_IDX_W  = 3;
  localparam int PFX_W      = 3;
  typedef enum logic {PH_IDLE = 1'b0, PH_HALF = 1'b1} phase_t;
endpackage

// File: rtl/srch_phase_fsm.sv
module srch_phase_fsm
  import srch_cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  input  logic       cmd_b2,
  output logic       first_take,
  output logic       second_ok,
  output logic       start_pulse,
  output logic       err_pulse
);
  phase_t phase_q;
  logic   is_search;
  logic   second_bad;

  assign is_search  = cmd_valid && (cmd_code == CODE_SEARCH);
  assign first_take = (phase_q == PH_IDLE) && is_search && !cmd_b2;
  assign second_ok  = (phase_q == PH_HALF) && is_search;
  assign second_bad = (phase_q == PH_HALF) && !is_search;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      start_pulse <= 1'b0;
      err_pulse   <= 1'b0;
    end else begin
      start_pulse <= second_ok;
      err_pulse   <= second_bad;
      if (first_take)                  phase_q <= PH_HALF;
      else if (second_ok || second_bad) phase_q <= PH_IDLE;
    end
  end

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(cmd_valid) && $past(cmd_code) == CODE_SEARCH));
  assert_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && err_pulse));
  assert_err_after_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(phase_q) == PH_HALF);
endmodule

// File: rtl/srch_key_capture.sv
module srch_key_capture
  import srch_cap_pkg::*;
#(
  parameter int DATA_W = 72,
  localparam int KEY_W = 2 * DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  first_take,
  input  logic                  second_ok,
  input  logic [8:3]            arg_hi,
  input  logic                  arg_b2,
  input  logic                  ext,
  input  logic [DATA_W-1:0]     data,
  output logic [KEY_W-1:0]      wr_key,
  output logic [CMP_IDX_W-1:0]  wr_sel,
  output logic [KEY_W-1:0]      key_o,
  output logic [MASK_IDX_W-1:0] mask_o,
  output logic [CMP_IDX_W-1:0]  cmp_o,
  output logic [RES_IDX_W-1:0]  res_o,
  output logic [PFX_W-1:0]      pfx_o
);
  logic [DATA_W-1:0]     hi_q;
  logic [MASK_IDX_W-1:0] mask_q;
  logic [PFX_W-1:0]      pfx_q;

  assign wr_key = {hi_q, data};
  assign wr_sel = {arg_hi[5:3], arg_b2};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      mask_q <= '0;
      pfx_q  <= '0;
      key_o  <= '0;
      mask_o <= '0;
      cmp_o  <= '0;
      res_o  <= '0;
      pfx_o  <= '0;
    end else begin
      if (first_take) begin
        hi_q   <= data;
        mask_q <= {ext, arg_hi[5:3]};
        pfx_q  <= arg_hi[8:6];
      end
      if (second_ok) begin
        key_o  <= wr_key;
        mask_o <= mask_q;
        pfx_o  <= pfx_q;
        res_o  <= arg_hi[8:6];
        cmp_o  <= wr_sel;
      end
    end
  end

  assert_key_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !second_ok |=> $stable(key_o) && $stable(mask_o) && $stable(res_o));
endmodule

// File: rtl/srch_cmp_bank.sv
module srch_cmp_bank #(
  parameter int KEY_W   = 144,
  parameter int N_PAIRS = 16,
  localparam int SEL_W  = $clog2(N_PAIRS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [KEY_W-1:0] rd_key
);
  logic [KEY_W-1:0] pair_q [N_PAIRS];

  for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rst_n)                                   pair_q[i] <= '0;
      else if (wr_en && wr_sel == SEL_W'(i))        pair_q[i] <= wr_key;
    end
  end

  assign rd_key = pair_q[rd_sel];

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pair_q[$past(wr_sel)] == $past(wr_key));
endmodule

// File: rtl/srch_cmd_capture.sv
module srch_cmd_capture
  import srch_cap_pkg::*;
#(
  parameter int DATA_W = 72,
  localparam int KEY_W = 2 * DATA_W,
  localparam int N_PAIRS = 1 << CMP_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_code,
  input  logic [8:2]            cmd_arg,
  input  logic                  cmd_ext,
  input  logic [DATA_W-1:0]     cmd_data,
  input  logic [CMP_IDX_W-1:0]  cmp_rd_sel,
  output logic [KEY_W-1:0]      cmp_rd_key,
  output logic                  search_start,
  output logic [KEY_W-1:0]      search_key,
  output logic [MASK_IDX_W-1:0] search_mask_sel,
  output logic [CMP_IDX_W-1:0]  search_cmp_sel,
  output logic [RES_IDX_W-1:0]  search_res_sel,
  output logic [PFX_W-1:0]      search_addr_hi,
  output logic                  proto_err
);
  logic                 first_take, second_ok;
  logic [KEY_W-1:0]     wr_key;
  logic [CMP_IDX_W-1:0] wr_sel;

  srch_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_b2(cmd_arg[2]), .first_take(first_take), .second_ok(second_ok),
    .start_pulse(search_start), .err_pulse(proto_err)
  );

  srch_key_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .first_take(first_take), .second_ok(second_ok),
    .arg_hi(cmd_arg[8:3]), .arg_b2(cmd_arg[2]), .ext(cmd_ext), .data(cmd_data),
    .wr_key(wr_key), .wr_sel(wr_sel), .key_o(search_key),
    .mask_o(search_mask_sel), .cmp_o(search_cmp_sel), .res_o(search_res_sel),
    .pfx_o(search_addr_hi)
  );

  srch_cmp_bank #(.KEY_W(KEY_W), .N_PAIRS(N_PAIRS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(second_ok), .wr_sel(wr_sel),
    .wr_key(wr_key), .rd_sel(cmp_rd_sel), .rd_key(cmp_rd_key)
  );

  assert_start_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
    search_start |-> !proto_err);
endmodule

// File: tb/test_srch_cmd_capture.sv
module test_srch_cmd_capture;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_code = 2'b00;
  logic [8:2]   cmd_arg = '0;
  logic         cmd_ext = 1'b0;
  logic [71:0]  cmd_data = '0;
  logic [3:0]   cmp_rd_sel = '0;
  logic [143:0] cmp_rd_key;
  logic         search_start;
  logic [143:0] search_key;
  logic [3:0]   search_mask_sel, search_cmp_sel;
  logic [2:0]   search_res_sel, search_addr_hi;
  logic         proto_err;

  typedef struct packed {
    logic [143:0] key;
    logic [3:0]   mask;
    logic [3:0]   cmp;
    logic [2:0]   res;
    logic [2:0]   pfx;
  } exp_t;

  exp_t         sb_q[$];
  logic [143:0] model [16];
  int checks = 0, failures = 0;
  int err_expected = 0, err_seen = 0, starts_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  srch_cmd_capture i_srch_cmd_capture (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_arg(cmd_arg), .cmd_ext(cmd_ext), .cmd_data(cmd_data),
    .cmp_rd_sel(cmp_rd_sel), .cmp_rd_key(cmp_rd_key),
    .search_start(search_start), .search_key(search_key),
    .search_mask_sel(search_mask_sel), .search_cmp_sel(search_cmp_sel),
    .search_res_sel(search_res_sel), .search_addr_hi(search_addr_hi),
    .proto_err(proto_err)
  );

  task automatic check(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_valid = 1'b0; cmd_code = 2'b00; cmd_arg = '0; cmd_ext = 1'b0;
    end
  endtask

  // Driver: two command cycles, expected request pushed to the scoreboard
  task automatic send_search(input logic [71:0] hi, input logic [71:0] lo,
                             input logic [3:0] mask, input logic [2:0] pfx,
                             input logic [3:0] cmp, input logic [2:0] res);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 2'b10; cmd_ext = mask[3];
    cmd_arg = {pfx, mask[2:0], 1'b0}; cmd_data = hi;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 2'b10; cmd_ext = 1'b0;
    cmd_arg = {res, cmp}; cmd_data = lo;
    e.key = {hi, lo}; e.mask = mask; e.cmp = cmp; e.res = res; e.pfx = pfx;
    sb_q.push_back(e);
    model[cmp] = {hi, lo};
  endtask

  // First cycle valid, second cycle broken (R9)
  task automatic send_broken(input logic [71:0] hi, input bit drop_valid);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 2'b10; cmd_ext = 1'b1;
    cmd_arg = 7'b1011010; cmd_data = hi;
    @(negedge clk);
    cmd_valid = !drop_valid; cmd_code = drop_valid ? 2'b10 : 2'b01;
    cmd_arg = 7'b0000011; cmd_data = ~hi;
    err_expected++;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (proto_err) err_seen++;
      if (search_start) begin
        starts_seen++;
        if (sb_q.size() == 0) begin
          check(1'b0, "R2 unexpected search_start", 144'd1, 144'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(search_key == e.key, "R3 key", search_key, e.key);
          check(search_mask_sel == e.mask, "R4 mask index", 144'(search_mask_sel), 144'(e.mask));
          check(search_addr_hi == e.pfx, "R5 address prefix", 144'(search_addr_hi), 144'(e.pfx));
          check(search_res_sel == e.res, "R6 result index", 144'(search_res_sel), 144'(e.res));
          check(search_cmp_sel == e.cmp, "R7 comparand index", 144'(search_cmp_sel), 144'(e.cmp));
          cmp_rd_sel = e.cmp;
          #0;
          check(cmp_rd_key == e.key, "R7 comparand write", cmp_rd_key, e.key);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(search_start == 1'b0, "R1 search_start low", 144'(search_start), 144'd0);
    check(proto_err == 1'b0, "R1 proto_err low", 144'(proto_err), 144'd0);
    for (int i = 0; i < 16; i++) begin
      cmp_rd_sel = 4'(i);
      #0;
      check(cmp_rd_key == '0, "R1 comparand zero", cmp_rd_key, 144'd0);
    end

    // R2 single search
    send_search(72'hA1B2C3D4E5F6071829, 72'h0123456789ABCDEF01, 4'hB, 3'd5, 4'd3, 3'd6);
    idle(3);
    check(starts_seen == 1, "R2 one start", 144'(starts_seen), 144'd1);

    // R10 back-to-back searches
    send_search({8'hFF, 64'h0}, {64'h0, 8'hFF}, 4'h0, 3'd0, 4'd0, 3'd0);
    send_search(72'h5555_5555_5555_5555_55, 72'hAAAA_AAAA_AAAA_AAAA_AA, 4'hF, 3'd7, 4'd15, 3'd7);
    send_search(72'h1, 72'h2, 4'h8, 3'd2, 4'd9, 3'd1);
    idle(2);
    check(starts_seen == 4, "R10 back-to-back starts", 144'(starts_seen), 144'd4);

    // R9 broken second cycles
    send_broken(72'hDEAD_BEEF_0000_1111_22, 1'b1);
    idle(2);
    check(err_seen == 1, "R9 error pulse on dropped valid", 144'(err_seen), 144'd1);
    send_broken(72'h33, 1'b0);
    idle(1);
    send_broken(72'h44, 1'b1);
    send_search(72'h77, 72'h88, 4'h6, 3'd3, 4'd6, 3'd4);
    idle(3);

    // R8 cycles that must not open a search; follow-up uses odd cmp so bit 2 = 1
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 2'b10; cmd_arg = 7'b0000001; cmd_data = 72'h99;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 2'b10; cmd_arg = 7'b0000111; cmd_data = 72'h9A;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 2'b11; cmd_arg = 7'b0000000; cmd_data = 72'h9B;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 2'b10; cmd_arg = 7'b0000000; cmd_data = 72'h9C;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 2'b10; cmd_arg = 7'b0000101; cmd_data = 72'h9D;
    idle(3);
    check(search_start == 1'b0 && proto_err == 1'b0, "R8 ignored cycles", 144'({search_start, proto_err}), 144'd0);
    check(search_key == {72'h77, 72'h88}, "R11 key held", search_key, {72'h77, 72'h88});
    check(search_res_sel == 3'd4, "R11 result index held", 144'(search_res_sel), 144'd4);

    check(starts_seen == 5, "R2 total starts", 144'(starts_seen), 144'd5);
    check(err_seen == err_expected, "R9 total error pulses", 144'(err_seen), 144'(err_expected));
    check(sb_q.size() == 0, "R2 scoreboard drained", 144'(sb_q.size()), 144'd0);
    for (int i = 0; i < 16; i++) begin
      cmp_rd_sel = 4'(i);
      #0;
      check(cmp_rd_key == model[i], "R7 comparand sweep", cmp_rd_key, model[i]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule